// File: doc/BRIEF.md
# Coefficient Reorder Buffer (Parallel In, Serial Out)

This block sits after a transform engine that finishes a whole 8x8 block at once. In a single cycle it captures 64 signed 16-bit coefficients from a wide parallel bus. It then hands them one word per cycle to a downstream scan stage over a valid/ready stream. Word 63 of each block is tagged with an end-of-block flag.

There are two storage banks that work as a ping-pong pair. One bank drains toward the consumer while the other can take the next block. The load side has no ready handshake of its own. A stall output tells the producer that both banks hold unread blocks, and a load offered while the stall is high is discarded. The transform itself and the generation of a scan order are not part of this block.

Top module: `coef_reorder_buf`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid_o` and `load_stall_o` are low.
- R2: A block loaded into an empty buffer makes `out_valid_o` rise on the next cycle. The first word presented is coefficient index 0, taken from bits [15:0] of `load_data_i`.
- R3: The words leave in index order 0 to 63, with index j taken from `load_data_i[16*j +: 16]`. The index advances once per cycle in which `out_valid_o` and `out_ready_i` are both high. While `out_ready_i` is low, the presented word stays unchanged.
- R4: `out_last_o` is high only while word 63 of a block is presented.
- R5: A block loaded while another block drains is streamed immediately after word 63 of the first block, with no idle cycle between them.
- R6: `load_stall_o` is high exactly when both banks hold blocks that are not fully read. A load offered while it is high is discarded: it never reaches the output.
- R7: A load accepted in the same cycle as the final handshake of the draining block is presented starting on the next cycle, beginning at index 0.
- R8: `load_stall_o` falls in the cycle after word 63 of the draining bank is accepted.
- R9: When the last word of the only stored block is accepted, `out_valid_o` drops on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_valid_i | input | 1 | Parallel block offered this cycle |
| load_data_i | input | 1024 | 64 coefficients; index j in bits [16*j +: 16] |
| load_stall_o | output | 1 | Both banks occupied; load is ignored |
| out_valid_o | output | 1 | Output word available |
| out_ready_i | input | 1 | Consumer accepts the word |
| out_data_o | output | 16 | Current coefficient |
| out_last_o | output | 1 | Current word is index 63 |

## Verification
A single block is drained with the consumer always ready, which shows the start latency, the index order and the end-of-block flag. A second block is drained with ready low on alternate cycles, which separates a correct hold from an index that advances or data that changes under backpressure. Two blocks are then loaded back to back and a third is offered while stalled. This shows that the hand-over between banks has no gap, that the stall falls at the right time, and that the stalled load really disappears. A final run lands a load in the exact cycle of the last handshake, the one case where the bank swap depends on a write made in that same cycle.

// File: rtl/coef_reorder_pkg.sv
`timescale 1ns/1ps
package coef_reorder_pkg;
  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_sel_e;
endpackage

// File: rtl/coef_bank.sv
`timescale 1ns/1ps
module coef_bank #(
  parameter int N_WORDS = 64,
  parameter int WORD_W  = 16,
  localparam int IDX_W  = $clog2(N_WORDS)
) (
  input  logic                      clk_i,
  input  logic                      wr_en_i,
  input  logic [N_WORDS*WORD_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output logic [WORD_W-1:0]         rd_data_o
);
  logic [WORD_W-1:0] mem_q [N_WORDS];

  // whole block captured in one cycle; data path needs no reset
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (wr_en_i) mem_q[w] <= wr_data_i[w*WORD_W +: WORD_W];
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/coef_drain_ctrl.sv
`timescale 1ns/1ps
module coef_drain_ctrl
  import coef_reorder_pkg::*;
#(
  parameter int N_WORDS = 64,
  localparam int IDX_W  = $clog2(N_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_valid_i,
  input  logic             out_ready_i,
  output logic [1:0]       wr_en_o,
  output bank_sel_e        rd_sel_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             out_valid_o,
  output logic             out_last_o,
  output logic             stall_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  logic [1:0]       full_q, full_d;
  bank_sel_e        sel_q;
  logic [IDX_W-1:0] idx_q;
  logic             wr_bank, load_acc, fire;

  assign stall_o     = &full_q;
  assign out_valid_o = full_q[sel_q];
  assign out_last_o  = out_valid_o && (idx_q == LAST_IDX);
  assign fire        = out_valid_o && out_ready_i;
  // fill the draining bank only if it is empty, else the other one
  assign wr_bank     = full_q[sel_q] ? ~sel_q : sel_q;
  assign load_acc    = load_valid_i && !stall_o;
  assign wr_en_o     = load_acc ? (2'b01 << wr_bank) : 2'b00;

  always_comb begin
    full_d = full_q;
    if (fire && out_last_o) full_d[sel_q] = 1'b0;
    if (load_acc)           full_d[wr_bank] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= '0;
      sel_q  <= BANK_A;
      idx_q  <= '0;
    end else begin
      full_q <= full_d;
      if (fire) begin
        if (out_last_o) begin
          idx_q <= '0;
          // swap includes a load landing in this very cycle
          if (full_d[~sel_q]) sel_q <= bank_sel_e'(~sel_q);
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign rd_sel_o = sel_q;
  assign rd_idx_o = idx_q;

  AST_STALL_HAS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> out_valid_o); // R6
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !out_last_o |=> idx_q == $past(idx_q) + 1'b1); // R3
  AST_FIRST_WORD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !$past(out_valid_o) |-> idx_q == '0); // R2
  AST_WRAP_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && out_last_o |=> idx_q == '0); // R4
endmodule

// File: rtl/coef_reorder_buf.sv
`timescale 1ns/1ps
module coef_reorder_buf
  import coef_reorder_pkg::*;
#(
  parameter int N_WORDS = 64,
  parameter int WORD_W  = 16,
  localparam int IDX_W  = $clog2(N_WORDS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_valid_i,
  input  logic [N_WORDS*WORD_W-1:0] load_data_i,
  output logic                      load_stall_o,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [WORD_W-1:0]         out_data_o,
  output logic                      out_last_o
);
  logic [1:0]        wr_en;
  bank_sel_e         rd_sel;
  logic [IDX_W-1:0]  rd_idx;
  logic [WORD_W-1:0] bank_data [2];

  coef_drain_ctrl #(.N_WORDS(N_WORDS)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_valid_i(load_valid_i),
    .out_ready_i (out_ready_i),
    .wr_en_o     (wr_en),
    .rd_sel_o    (rd_sel),
    .rd_idx_o    (rd_idx),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .stall_o     (load_stall_o)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    coef_bank #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) i_bank (
      .clk_i    (clk_i),
      .wr_en_i  (wr_en[b]),
      .wr_data_i(load_data_i),
      .rd_idx_i (rd_idx),
      .rd_data_o(bank_data[b])
    );
  end

  assign out_data_o = (rd_sel == BANK_B) ? bank_data[1] : bank_data[0];

  AST_HOLD_UNDER_BACKPRESSURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R3
  AST_NO_WRITE_TO_DRAINING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !(wr_en[0] && rd_sel == BANK_A) && !(wr_en[1] && rd_sel == BANK_B)); // R3
endmodule

// File: tb/test_coef_reorder_buf.sv
`timescale 1ns/1ps
module test_coef_reorder_buf;
  localparam int NW = 64;
  localparam int WW = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             load_valid_i = 1'b0;
  logic [NW*WW-1:0] load_data_i = '0;
  logic             load_stall_o;
  logic             out_valid_o;
  logic             out_ready_i = 1'b0;
  logic [WW-1:0]    out_data_o;
  logic             out_last_o;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  coef_reorder_buf i_coef_reorder_buf (.*);

  function automatic logic [WW-1:0] pat(input int seed, input int j);
    return {seed[7:0], j[7:0]} ^ 16'h5A00;
  endfunction

  task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one-cycle parallel load; caller is at a negedge
  task automatic load_block(input int seed);
    for (int j = 0; j < NW; j++) load_data_i[j*WW +: WW] = pat(seed, j);
    load_valid_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    load_valid_i = 1'b0;
  endtask

  // drains cnt words starting at index 0; gap inserts a held cycle on even words
  task automatic drain(input int seed, input int cnt, input bit gap, input string req);
    for (int j = 0; j < cnt; j++) begin
      if (gap && (j % 2 == 0)) begin
        out_ready_i = 1'b0;
        #1 check(out_valid_o, req, {15'b0, out_valid_o}, 16'h1);
        @(posedge clk_i); @(negedge clk_i);
        #1 check(out_data_o == pat(seed, j), "R3 hold", out_data_o, pat(seed, j));
      end
      out_ready_i = 1'b1;
      #1 check(out_valid_o, req, {15'b0, out_valid_o}, 16'h1);
      check(out_data_o == pat(seed, j), "R3 order", out_data_o, pat(seed, j));
      check(out_last_o == (j == NW - 1), "R4", {15'b0, out_last_o}, {15'b0, j == NW - 1});
      @(posedge clk_i); @(negedge clk_i);
    end
    out_ready_i = 1'b0;
  endtask

  task automatic t_reset;
    #1 check(!out_valid_o && !load_stall_o, "R1 in reset", {14'b0, out_valid_o, load_stall_o}, 16'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    #1 check(!out_valid_o && !load_stall_o, "R1 after", {14'b0, out_valid_o, load_stall_o}, 16'h0);
  endtask

  task automatic t_single;
    load_block(1);
    #1 check(out_valid_o, "R2 valid", {15'b0, out_valid_o}, 16'h1);
    check(out_data_o == pat(1, 0), "R2 word0", out_data_o, pat(1, 0));
    drain(1, NW, 1'b0, "R3");
    #1 check(!out_valid_o, "R9 empty", {15'b0, out_valid_o}, 16'h0);
  endtask

  task automatic t_backpressure;
    load_block(2);
    drain(2, NW, 1'b1, "R3 bp");
    #1 check(!out_valid_o, "R9 empty bp", {15'b0, out_valid_o}, 16'h0);
  endtask

  task automatic t_pingpong;
    load_block(3);
    #1 check(!load_stall_o, "R6 one bank", {15'b0, load_stall_o}, 16'h0);
    load_block(4);
    #1 check(load_stall_o, "R6 both full", {15'b0, load_stall_o}, 16'h1);
    load_block(5); // discarded
    #1 check(load_stall_o, "R6 still full", {15'b0, load_stall_o}, 16'h1);
    drain(3, NW, 1'b0, "R5 first");
    #1 check(!load_stall_o, "R8 stall drop", {15'b0, load_stall_o}, 16'h0);
    drain(4, NW, 1'b0, "R5 no gap");
    #1 check(!out_valid_o, "R6 stalled load dropped", {15'b0, out_valid_o}, 16'h0);
  endtask

  task automatic t_coincident;
    load_block(6);
    drain(6, NW - 1, 1'b0, "R3 pre");
    for (int j = 0; j < NW; j++) load_data_i[j*WW +: WW] = pat(7, j);
    load_valid_i = 1'b1;
    out_ready_i  = 1'b1;
    #1 check(out_last_o && out_data_o == pat(6, NW - 1), "R4 last", out_data_o, pat(6, NW - 1));
    @(posedge clk_i); @(negedge clk_i);
    load_valid_i = 1'b0;
    out_ready_i  = 1'b0;
    #1 check(out_valid_o && out_data_o == pat(7, 0), "R7 swap", out_data_o, pat(7, 0));
    drain(7, NW, 1'b0, "R7");
    #1 check(!out_valid_o, "R9 end", {15'b0, out_valid_o}, 16'h0);
  endtask

  initial begin
    #3000000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_backpressure();
    t_pingpong();
    t_coincident();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule